// File: doc/BRIEF.md
# Chip Erase Algorithm Sequencer

This block is a host-side controller that runs a complete, verified whole-array erase on an external byte-wide flash device. The flash is reached through a command-driven parallel interface. After a one-cycle start request, the block raises a request for the high programming supply and waits until the supply is reported ready. It then clears every byte to 00h, using a program, verify and retry loop. Only after that does it apply erase pulses and check the array one byte at a time, from the lowest address upwards.

Each erase pulse is two consecutive erase commands followed by a long timed wait. After every pulse, verification continues from the byte that failed, not from address zero. The number of pulses is a single budget shared by the whole erase. The run ends with a one-cycle done pulse or a one-cycle error pulse. All waits are counted in clock cycles and set by parameters, so a test environment can shorten them.

Top module: `chip_erase_seq`

## Requirements
- R1: After reset, and while no run is active, the bus is idle: chip enable, output enable and write enable are all high (inactive), the supply request is low, and done and error are low.
- R2: A start request raises the supply request. No write cycle is issued before the supply-ready input is high.
- R3: Pre-clear runs from address 0 upwards. For each byte the sequence is: write 40h, write 00h at the byte address, wait PROG_WAIT cycles, write C0h, wait VFY_WAIT cycles, then read. A read of 00h moves on to the next byte. Any other value repeats the program pulse for the same byte. A byte that has had PP_LIMIT pulses and still fails ends the run with an error.
- R4: No erase command is written until every byte has read back 00h.
- R5: One erase pulse is two writes of 20h followed by a wait of ERASE_WAIT cycles.
- R6: After each pulse, verification writes A0h with the byte address, waits VFY_WAIT cycles and reads. FFh moves on to the next address. Any other value starts a new pulse, and verification then resumes at the same address. The verified address never decreases within a run.
- R7: The pulse count starts at 0 for each run and is never reset inside the run. A run issues at most ER_LIMIT pulses. A byte that needs exactly ER_LIMIT pulses still completes without error.
- R8: After the last address reads FFh, the block writes 00h (return to read mode), drops the supply request, and pulses done high for exactly one cycle.
- R9: When either retry budget runs out, the block drops the supply request and pulses error high for one cycle, without writing 00h.
- R10: A start request while a run is active is ignored. The run keeps its pulse count and produces exactly one done or error pulse.
- R11: A write cycle drives write enable low for exactly one cycle, then high for one cycle. Chip enable stays low across both cycles and address and data are held. Output enable and write enable are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle request to begin a chip erase |
| vpp_ok_i | input | 1 | Programming supply is at level |
| rdata_i | input | 8 | Data read from the flash |
| vpp_req_o | output | 1 | Request for the programming supply |
| ce_n_o | output | 1 | Chip enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low; command latched on its rising edge |
| addr_o | output | ADDR_W | Byte address |
| wdata_o | output | 8 | Command or data byte |
| done_o | output | 1 | One-cycle pulse: erase completed |
| err_o | output | 1 | One-cycle pulse: retry budget exhausted |

## Verification
The bench drives a behavioural flash model in which each byte needs its own number of program pulses and erase pulses. Per-byte pulse needs are placed at the first and last addresses, just below and just above each limit.

A sequencer that restarts verification at address zero would show a decreasing verify address. A sequencer that resets the pulse count per byte would either give more pulses than the budget allows or miss the error. A sequencer that erases before the pre-clear completes would be caught when the model sees nonzero bytes at the first pulse.

An off-by-one in either limit would fail the exact-limit vectors. Restarting on a second start request would change the pulse totals or the number of done pulses.

// File: rtl/ces_pkg.sv
package ces_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_ERASE     = 8'h20;
    localparam logic [BYTE_W-1:0] OPC_ERASE_VFY = 8'hA0;
    localparam logic [BYTE_W-1:0] OPC_PROG      = 8'h40;
    localparam logic [BYTE_W-1:0] OPC_PROG_VFY  = 8'hC0;
    localparam logic [BYTE_W-1:0] OPC_READ      = 8'h00;
    localparam logic [BYTE_W-1:0] BYTE_CLEAR    = 8'h00;
    localparam logic [BYTE_W-1:0] BYTE_ERASED   = 8'hFF;

    typedef enum logic [1:0] {
        BUS_NONE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_op_e;

    typedef struct packed {
        bus_op_e             op;
        logic [BYTE_W-1:0]   data;
    } bus_req_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_VPP,
        S_PP_CMD,
        S_PP_DATA,
        S_PP_WAIT,
        S_PP_VCMD,
        S_PP_VWAIT,
        S_PP_RD,
        S_ER_CMD1,
        S_ER_CMD2,
        S_ER_WAIT,
        S_EV_CMD,
        S_EV_WAIT,
        S_EV_RD,
        S_RD_CMD,
        S_FIN
    } seq_state_e;

    function automatic int unsigned umax3(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ces_bus_cycle.sv
module ces_bus_cycle
    import ces_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int RD_CYC = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_vld,
    input  bus_req_t            req,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                ack,
    output logic                ce_n,
    output logic                oe_n,
    output logic                we_n,
    output logic [ADDR_W-1:0]   addr,
    output logic [BYTE_W-1:0]   wdata
);
    localparam int RC_W = (RD_CYC > 1) ? $clog2(RD_CYC) : 1;

    typedef enum logic [1:0] {BC_IDLE, BC_WLO, BC_WHI, BC_RD} bc_state_e;

    bc_state_e          st_q;
    logic [RC_W-1:0]    cnt_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [BYTE_W-1:0]  data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= BC_IDLE;
            cnt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            case (st_q)
                BC_IDLE: begin
                    if (req_vld && req.op != BUS_NONE) begin
                        addr_q <= req_addr;
                        data_q <= req.data;
                        if (req.op == BUS_WRITE) begin
                            st_q <= BC_WLO;
                        end else begin
                            st_q  <= BC_RD;
                            cnt_q <= RC_W'(RD_CYC - 1);
                        end
                    end
                end
                BC_WLO: st_q <= BC_WHI;
                BC_WHI: st_q <= BC_IDLE;
                BC_RD: begin
                    if (cnt_q == '0) st_q <= BC_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= BC_IDLE;
            endcase
        end
    end

    always_comb begin
        ack   = (st_q == BC_WHI) || (st_q == BC_RD && cnt_q == '0);
        ce_n  = (st_q == BC_IDLE);
        we_n  = (st_q != BC_WLO);
        oe_n  = (st_q != BC_RD);
        addr  = addr_q;
        wdata = data_q;
    end

endmodule

// File: rtl/ces_wait_timer.sv
module ces_wait_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             fire
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= len;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q <= CNT_W'(1)) run_q <= 1'b0;
            else                    cnt_q <= cnt_q - 1'b1;
        end
    end

    assign fire = run_q && (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
    import ces_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int ER_LIMIT   = 1000,
    parameter int PP_LIMIT   = 25,
    parameter int ERASE_WAIT = 500000,
    parameter int PROG_WAIT  = 500,
    parameter int VFY_WAIT   = 300,
    parameter int RD_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              vpp_ok_i,
    input  logic [7:0]        rdata_i,
    output logic              vpp_req_o,
    output logic              ce_n_o,
    output logic              oe_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        wdata_o,
    output logic              done_o,
    output logic              err_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam int EC_W = $clog2(ER_LIMIT + 1);
    localparam int PC_W = $clog2(PP_LIMIT + 1);
    localparam int TM_W = $clog2(umax3(ERASE_WAIT, PROG_WAIT, VFY_WAIT) + 1);

    seq_state_e         state_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [EC_W-1:0]    er_cnt_q;
    logic [PC_W-1:0]    pp_cnt_q;
    logic               fail_q;
    logic               issued_q;

    bus_req_t           bus_req;
    logic               req_vld;
    logic               bus_ack;
    logic               is_wait;
    logic [TM_W-1:0]    tm_len;
    logic               tm_load;
    logic               tm_fire;
    logic               adv;

    always_comb begin
        bus_req.op   = BUS_NONE;
        bus_req.data = '0;
        is_wait      = 1'b0;
        tm_len       = TM_W'(VFY_WAIT);
        case (state_q)
            S_PP_CMD:  begin bus_req.op = BUS_WRITE; bus_req.data = OPC_PROG;      end
            S_PP_DATA: begin bus_req.op = BUS_WRITE; bus_req.data = BYTE_CLEAR;    end
            S_PP_VCMD: begin bus_req.op = BUS_WRITE; bus_req.data = OPC_PROG_VFY;  end
            S_ER_CMD1,
            S_ER_CMD2: begin bus_req.op = BUS_WRITE; bus_req.data = OPC_ERASE;     end
            S_EV_CMD:  begin bus_req.op = BUS_WRITE; bus_req.data = OPC_ERASE_VFY; end
            S_RD_CMD:  begin bus_req.op = BUS_WRITE; bus_req.data = OPC_READ;      end
            S_PP_RD,
            S_EV_RD:   bus_req.op = BUS_READ;
            S_PP_WAIT: begin is_wait = 1'b1; tm_len = TM_W'(PROG_WAIT);  end
            S_ER_WAIT: begin is_wait = 1'b1; tm_len = TM_W'(ERASE_WAIT); end
            S_PP_VWAIT,
            S_EV_WAIT: is_wait = 1'b1;
            default: ;
        endcase
        req_vld = (bus_req.op != BUS_NONE) && !issued_q;
        tm_load = is_wait && !issued_q;
        adv     = issued_q && (is_wait ? tm_fire : bus_ack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            addr_q   <= '0;
            er_cnt_q <= '0;
            pp_cnt_q <= '0;
            fail_q   <= 1'b0;
            issued_q <= 1'b0;
        end else begin
            if (req_vld || tm_load) issued_q <= 1'b1;
            if (adv)                issued_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        state_q  <= S_VPP;
                        addr_q   <= '0;
                        er_cnt_q <= '0;
                        pp_cnt_q <= '0;
                        fail_q   <= 1'b0;
                    end
                end
                S_VPP:      if (vpp_ok_i) state_q <= S_PP_CMD;
                S_PP_CMD:   if (adv) state_q <= S_PP_DATA;
                S_PP_DATA:  if (adv) state_q <= S_PP_WAIT;
                S_PP_WAIT:  if (adv) state_q <= S_PP_VCMD;
                S_PP_VCMD:  if (adv) state_q <= S_PP_VWAIT;
                S_PP_VWAIT: if (adv) state_q <= S_PP_RD;
                S_PP_RD: begin
                    if (adv) begin
                        if (rdata_i == BYTE_CLEAR) begin
                            pp_cnt_q <= '0;
                            if (addr_q == LAST_ADDR) begin
                                addr_q  <= '0;
                                state_q <= S_ER_CMD1;
                            end else begin
                                addr_q  <= addr_q + 1'b1;
                                state_q <= S_PP_CMD;
                            end
                        end else if ((pp_cnt_q + PC_W'(1)) == PC_W'(PP_LIMIT)) begin
                            fail_q  <= 1'b1;
                            state_q <= S_FIN;
                        end else begin
                            pp_cnt_q <= pp_cnt_q + 1'b1;
                            state_q  <= S_PP_CMD;
                        end
                    end
                end
                S_ER_CMD1:  if (adv) state_q <= S_ER_CMD2;
                S_ER_CMD2:  if (adv) state_q <= S_ER_WAIT;
                S_ER_WAIT:  if (adv) state_q <= S_EV_CMD;
                S_EV_CMD:   if (adv) state_q <= S_EV_WAIT;
                S_EV_WAIT:  if (adv) state_q <= S_EV_RD;
                S_EV_RD: begin
                    if (adv) begin
                        if (rdata_i == BYTE_ERASED) begin
                            if (addr_q == LAST_ADDR) begin
                                state_q <= S_RD_CMD;
                            end else begin
                                addr_q  <= addr_q + 1'b1;
                                state_q <= S_EV_CMD;
                            end
                        end else if ((er_cnt_q + EC_W'(1)) == EC_W'(ER_LIMIT)) begin
                            er_cnt_q <= er_cnt_q + 1'b1;
                            fail_q   <= 1'b1;
                            state_q  <= S_FIN;
                        end else begin
                            er_cnt_q <= er_cnt_q + 1'b1;
                            state_q  <= S_ER_CMD1;
                        end
                    end
                end
                S_RD_CMD:   if (adv) state_q <= S_FIN;
                S_FIN:      state_q <= S_IDLE;
                default:    state_q <= S_IDLE;
            endcase
        end
    end

    ces_bus_cycle #(
        .ADDR_W (ADDR_W),
        .RD_CYC (RD_CYC)
    ) u_bus (
        .clk      (clk),
        .rst      (rst),
        .req_vld  (req_vld),
        .req      (bus_req),
        .req_addr (addr_q),
        .ack      (bus_ack),
        .ce_n     (ce_n_o),
        .oe_n     (oe_n_o),
        .we_n     (we_n_o),
        .addr     (addr_o),
        .wdata    (wdata_o)
    );

    ces_wait_timer #(
        .CNT_W (TM_W)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tm_load),
        .len  (tm_len),
        .fire (tm_fire)
    );

    assign vpp_req_o = (state_q != S_IDLE) && (state_q != S_FIN);
    assign done_o    = (state_q == S_FIN) && !fail_q;
    assign err_o     = (state_q == S_FIN) &&  fail_q;

endmodule

// File: rtl/ces_checker.sv
module ces_checker #(
    parameter int ADDR_W   = 18,
    parameter int EC_W     = 10,
    parameter int ER_LIMIT = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              vpp_req,
    input logic              vpp_ok,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              done,
    input logic              err,
    input logic [EC_W-1:0]   er_cnt
);
    AST_BUS_IDLE_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
        !vpp_req |-> (ce_n && oe_n && we_n)); // R1
    AST_NO_WRITE_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (vpp_ok && vpp_req)); // R2
    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n)); // R11
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> (we_n && !ce_n && oe_n)); // R11
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> ($stable(addr) && $stable(wdata))); // R11
    AST_PULSE_BUDGET: assert property (@(posedge clk) disable iff (rst)
        er_cnt <= EC_W'(ER_LIMIT)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
        done |-> (!vpp_req && !err)); // R8
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        err |=> !err); // R9
    AST_ERR_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
        err |-> !vpp_req); // R9
endmodule

bind chip_erase_seq ces_checker #(
    .ADDR_W   (ADDR_W),
    .EC_W     (EC_W),
    .ER_LIMIT (ER_LIMIT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .vpp_req (vpp_req_o),
    .vpp_ok  (vpp_ok_i),
    .ce_n    (ce_n_o),
    .oe_n    (oe_n_o),
    .we_n    (we_n_o),
    .addr    (addr_o),
    .wdata   (wdata_o),
    .done    (done_o),
    .err     (err_o),
    .er_cnt  (er_cnt_q)
);

// File: tb/chip_erase_seq_tb.sv
module chip_erase_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 3;
    localparam int NB  = 1 << AW;
    localparam int ERL = 6;
    localparam int PPL = 3;
    localparam int NV  = 6;

    // vector table: er base need, hot address, extra erase need, program need at hot,
    // expected error, expected erase pulses, expected program pulses
    localparam int V_BASE [NV] = '{1, 2, 1, 1, 1, 1};
    localparam int V_HOT  [NV] = '{0, 5, 7, 3, 0, 0};
    localparam int V_EXT  [NV] = '{0, 2, 5, 6, 0, 0};
    localparam int V_PPH  [NV] = '{1, 2, 1, 1, 3, 4};
    localparam int V_ERR  [NV] = '{0, 0, 0, 1, 0, 1};
    localparam int V_ERP  [NV] = '{1, 4, 6, 6, 1, 0};
    localparam int V_PPP  [NV] = '{8, 9, 8, 8, 10, 3};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic vpp_ok;
    logic [7:0] rdata;
    logic vpp_req, ce_n, oe_n, we_n, done, err;
    logic [AW-1:0] addr;
    logic [7:0] wdata;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chip_erase_seq #(
        .ADDR_W(AW), .ER_LIMIT(ERL), .PP_LIMIT(PPL),
        .ERASE_WAIT(20), .PROG_WAIT(5), .VFY_WAIT(3), .RD_CYC(2)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .vpp_ok_i(vpp_ok), .rdata_i(rdata),
        .vpp_req_o(vpp_req), .ce_n_o(ce_n), .oe_n_o(oe_n), .we_n_o(we_n),
        .addr_o(addr), .wdata_o(wdata), .done_o(done), .err_o(err)
    );

    // supply model: ready four cycles after the request
    logic [3:0] vpp_sr = '0;
    always @(negedge clk) vpp_sr <= {vpp_sr[2:0], vpp_req};
    assign vpp_ok = vpp_sr[3] && vpp_req;

    // flash model
    logic [7:0] mem [NB];
    int er_need [NB];
    int pp_need [NB];
    int pp_hits [NB];
    int cur_base, cur_hot, cur_ext, cur_pph;
    logic model_clr = 1'b0;
    int mode, er_pulses, pp_pulses, rd_cmds, vpp_viol, back_viol, pre_viol;
    int last_vaddr, done_cnt, err_cnt;
    logic prev_we;

    assign rdata = (!ce_n && !oe_n) ? mem[addr] : 8'hEE;

    always @(negedge clk) begin
        if (model_clr) begin
            for (int i = 0; i < NB; i++) begin
                mem[i]     = 8'(i * 37 + 11) | 8'h01;
                er_need[i] = (i == cur_hot) ? cur_base + cur_ext : cur_base;
                pp_need[i] = (i == cur_hot) ? cur_pph : 1;
                pp_hits[i] = 0;
            end
            mode = 0; er_pulses = 0; pp_pulses = 0; rd_cmds = 0;
            vpp_viol = 0; back_viol = 0; pre_viol = 0; last_vaddr = 0;
            done_cnt = 0; err_cnt = 0; prev_we = 1'b1;
        end else begin
            if (!ce_n && we_n && !prev_we) begin
                if (!vpp_ok) vpp_viol++;
                if (mode == 1) begin
                    pp_pulses++;
                    pp_hits[addr]++;
                    if (pp_hits[addr] >= pp_need[addr]) mem[addr] = mem[addr] & wdata;
                    mode = 0;
                end else begin
                    case (wdata)
                        8'h40: mode = 1;
                        8'h20: begin
                            if (mode == 2) begin
                                if (er_pulses == 0)
                                    for (int i = 0; i < NB; i++) if (mem[i] != 8'h00) pre_viol++;
                                er_pulses++;
                                for (int i = 0; i < NB; i++)
                                    if (er_pulses >= er_need[i]) mem[i] = 8'hFF;
                                mode = 0;
                            end else mode = 2;
                        end
                        8'hA0: begin
                            if (int'(addr) < last_vaddr) back_viol++;
                            last_vaddr = int'(addr);
                            mode = 0;
                        end
                        8'h00: begin rd_cmds++; mode = 0; end
                        default: mode = 0;
                    endcase
                end
            end
            prev_we = we_n;
            if (done) done_cnt++;
            if (err)  err_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input int v, input bit busy_starts);
        int cyc;
        int nonff;
        cur_base = V_BASE[v]; cur_hot = V_HOT[v]; cur_ext = V_EXT[v]; cur_pph = V_PPH[v];
        @(negedge clk) model_clr = 1'b1;
        @(negedge clk) begin model_clr = 1'b0; start = 1'b1; end
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (done_cnt + err_cnt == 0 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            start = busy_starts && (cyc == 40 || cyc == 120 || cyc == 300);
        end
        start = 1'b0;
        if (cyc >= 20000) chk(1'b0, "watchdog", cyc, 0);
        repeat (10) @(negedge clk);
        nonff = 0;
        for (int i = 0; i < NB; i++) if (mem[i] != 8'hFF) nonff++;
        chk(done_cnt == (V_ERR[v] ? 0 : 1), "R8 done pulses", done_cnt, V_ERR[v] ? 0 : 1);
        chk(err_cnt == V_ERR[v], "R9 R3 err pulses", err_cnt, V_ERR[v]);
        chk(er_pulses == V_ERP[v], "R7 R5 erase pulses", er_pulses, V_ERP[v]);
        chk(pp_pulses == V_PPP[v], "R3 program pulses", pp_pulses, V_PPP[v]);
        chk(rd_cmds == (V_ERR[v] ? 0 : 1), "R8 R9 read command", rd_cmds, V_ERR[v] ? 0 : 1);
        chk(vpp_viol == 0, "R2 write without supply", vpp_viol, 0);
        chk(back_viol == 0, "R6 verify address backwards", back_viol, 0);
        chk(pre_viol == 0, "R4 erase before pre-clear", pre_viol, 0);
        if (!V_ERR[v]) chk(nonff == 0, "R6 bytes left unerased", nonff, 0);
        chk(vpp_req == 1'b0 && ce_n == 1'b1, "R8 R9 supply and bus idle", vpp_req, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cur_base = 1; cur_hot = 0; cur_ext = 0; cur_pph = 1;
        model_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clr = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ce_n && oe_n && we_n, "R1 bus strobes idle", {ce_n, oe_n, we_n}, 7);
        chk(!vpp_req && !done && !err, "R1 request and status low", {vpp_req, done, err}, 0);
        repeat (20) @(negedge clk);
        chk(ce_n && !vpp_req, "R1 idle without start", {ce_n, vpp_req}, 2);

        for (int v = 0; v < NV; v++) run_vec(v, 1'b0);

        // R10 start requests during a run
        run_vec(1, 1'b1);
        chk(done_cnt + err_cnt == 1, "R10 single completion", done_cnt + err_cnt, 1);
        repeat (30) @(negedge clk);
        chk(vpp_req == 1'b0, "R10 no second run", vpp_req, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule